// File: doc/BRIEF.md
# Gate Stuck-At Test Sequencer

This block exercises one internal n-input gate model, fixed at build time as an AND or an OR, with its collapsed stuck-at test set. After a start strobe it puts one test pattern per cycle on the gate. Each pattern goes to a fault-free copy of the gate and to a copy that carries one fault picked by the fault-select input. The block shows the pattern, both outputs and a detect pulse for every pattern. Done is raised after the last pattern.

Alongside the selected fault, a bank of gate copies holds every fault of the collapsed list at once. These are each input stuck at its non-controlling value, the output stuck at the controlling-output value, and the output stuck at the opposite value. Each copy is compared against the fault-free output on every pattern. The block keeps a per-fault credited map and a coverage count of the distinct faults credited so far. The output fault that every input test also exposes is credited only by a pattern that exposes no input fault.

Input faults at the non-controlling value are modelled by removing the input from the gate. Input faults at the controlling value force that input. Output faults override the gate result.

Top module: `gfs_top`

## Requirements
- R1: After a start strobe the block applies exactly N+2 patterns, one per cycle, with pat_valid_o high. It then drops pat_valid_o and raises done_o.
- R2: For an AND gate, the test for input i has 0 on bit i and 1 on every other bit. For an OR gate, the test for input i has 1 on bit i and 0 on every other bit. An input test never carries a second controlling value.
- R3: The patterns come in a fixed order: input 0 through input N-1, then the all-non-controlling pattern (all ones for AND, all zeros for OR), then the all-controlling pattern (all zeros for AND, all ones for OR).
- R4: good_o is the fault-free gate output for pattern_o.
- R5: fault_sel_i encoding: bit IDXW+1 is the site (0 = input, 1 = output), bit IDXW is the stuck value, and bits IDXW-1:0 are the input index, with IDXW = clog2(N). An input fault stuck at the non-controlling value (1 for AND, 0 for OR) removes that input from the gate. An input fault stuck at the controlling value forces that input to it. faulty_o is the faulted gate output.
- R6: An output-site fault makes faulty_o equal to the stuck value, whatever the index bits hold.
- R7: detect_o is high in a pattern cycle exactly when good_o and faulty_o differ, and it is low outside pattern cycles.
- R8: credited_o bit e is set once fault e of the bank is detected. Bits 0..N-1 are inputs at the non-controlling value, bit N is the output stuck at the controlling-output value, and bit N+1 is the output stuck at the opposite value. coverage_o counts the set bits. Bit N+1 is credited only by a pattern that detects no input fault, so after the whole set coverage_o is N+2, and while pattern k<N is shown coverage_o equals k.
- R9: done_o holds until the next start strobe. A start strobe clears credited_o and coverage_o and restarts at the first pattern, even in the middle of a run.
- R10: After reset pat_valid_o, done_o, detect_o, credited_o and coverage_o are all zero.
- R11: An input-site fault whose index is N or above injects no fault, so faulty_o equals good_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe; clears tallies and starts the test set |
| fault_sel_i | input | IDXW+2 | Selected fault: site, stuck value, input index |
| pattern_o | output | N | Current test pattern |
| pat_valid_o | output | 1 | A pattern is being applied this cycle |
| good_o | output | 1 | Fault-free gate output |
| faulty_o | output | 1 | Output of the gate with the selected fault |
| detect_o | output | 1 | Selected fault detected by the current pattern |
| done_o | output | 1 | Test set finished |
| credited_o | output | N+2 | Per-fault credited map of the collapsed fault bank |
| coverage_o | output | clog2(N+3) | Number of distinct faults credited |

## Verification
The start strobe is taken at a clock edge. Pattern 0 and its good, faulty and detect values appear straight after that edge. Each later edge moves to the next pattern, and done_o appears one edge after the last pattern. Credits are registered, so the coverage count seen with pattern k reflects patterns 0..k-1, and the final count is seen together with done_o. The bench changes inputs and samples outputs on the falling edge, one sample per pattern, and compares each sample with the value due for that pattern.

// File: rtl/gfs_pkg.sv
package gfs_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_RUN  = 2'd1,
      SEQ_DONE = 2'd2
   } seq_state_e;

   // controlling input value of the gate kind
   function automatic logic ctl_val(input bit is_or);
      return is_or ? 1'b1 : 1'b0;
   endfunction

endpackage

// File: rtl/gfs_pattern_gen.sv
module gfs_pattern_gen #(
   parameter int N       = 4,
   parameter bit IS_OR   = 1'b0,
   parameter int CW      = 3
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          valid_i,
   input  logic [CW-1:0] idx_i,
   output logic [N-1:0]  pat_o
);
   import gfs_pkg::*;

   localparam logic CV = ctl_val(IS_OR);

   logic [N-1:0] onehot;

   always_comb begin
      onehot = '0;
      for (int i = 0; i < N; i++) begin
         if (idx_i == CW'(i)) onehot[i] = 1'b1;
      end
   end

   always_comb begin
      if (idx_i < CW'(N)) begin
         pat_o = CV ? onehot : ~onehot;
      end else if (idx_i == CW'(N)) begin
         pat_o = {N{~CV}};
      end else begin
         pat_o = {N{CV}};
      end
   end

   AST_ONE_CONTROLLING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && idx_i < CW'(N)) |-> ($countones(CV ? pat_o : ~pat_o) == 1)) // R2
      else $error("input test carries a blocking value");

endmodule

// File: rtl/gfs_gate_model.sv
module gfs_gate_model #(
   parameter int N     = 4,
   parameter bit IS_OR = 1'b0
) (
   input  logic [N-1:0] in_i,
   input  logic [N-1:0] remove_i,
   input  logic [N-1:0] force_i,
   input  logic         out_stuck_i,
   input  logic         out_val_i,
   output logic         out_o
);
   import gfs_pkg::*;

   localparam logic CV = ctl_val(IS_OR);

   logic [N-1:0] eff;
   logic         raw;

   // a removed input stops counting (non-controlling), a forced one controls
   always_comb begin
      for (int i = 0; i < N; i++) begin
         if (force_i[i])       eff[i] = CV;
         else if (remove_i[i]) eff[i] = ~CV;
         else                  eff[i] = in_i[i];
      end
   end

   generate
      if (IS_OR) begin : g_or
         assign raw = |eff;
      end else begin : g_and
         assign raw = &eff;
      end
   endgenerate

   assign out_o = out_stuck_i ? out_val_i : raw;

endmodule

// File: rtl/gfs_fault_bank.sv
module gfs_fault_bank #(
   parameter int N     = 4,
   parameter bit IS_OR = 1'b0,
   parameter int NF    = N + 2,
   parameter int CVW   = 3
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           clear_i,
   input  logic           valid_i,
   input  logic [N-1:0]   pat_i,
   input  logic           good_i,
   output logic [NF-1:0]  credited_o,
   output logic [CVW-1:0] coverage_o
);
   import gfs_pkg::*;

   localparam logic CV = ctl_val(IS_OR);

   logic [NF-1:0] fout;
   logic [NF-1:0] hit;
   logic [NF-1:0] credit;
   logic [NF-1:0] flags_q;

   // one faulty copy per entry of the collapsed list
   generate
      for (genvar e = 0; e < NF; e++) begin : g_copy
         localparam logic [N-1:0] RM = (e < N) ? (N'(1) << e) : '0;
         localparam logic         OS = (e >= N);
         localparam logic         OV = (e == N) ? CV : ~CV;
         gfs_gate_model #(.N(N), .IS_OR(IS_OR)) copy_i (
            .in_i        (pat_i),
            .remove_i    (RM),
            .force_i     ('0),
            .out_stuck_i (OS),
            .out_val_i   (OV),
            .out_o       (fout[e])
         );
         assign hit[e] = valid_i & (fout[e] ^ good_i);
      end
   endgenerate

   always_comb begin
      credit = hit;
      // the dominating output fault counts only on its own
      credit[NF-1] = hit[NF-1] & ~(|hit[N-1:0]);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      flags_q <= '0;
      else if (clear_i) flags_q <= '0;
      else              flags_q <= flags_q | credit;
   end

   always_comb begin
      coverage_o = '0;
      for (int e = 0; e < NF; e++) coverage_o = coverage_o + CVW'(flags_q[e]);
   end

   assign credited_o = flags_q;

   AST_OUT_CREDIT_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flags_q[NF-1]) |-> $past(~(|hit[N-1:0]))) // R8
      else $error("dominating output fault credited with an input fault");

   AST_COV_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ({1'b0, coverage_o} <= {1'b0, $past(coverage_o)} + 1'b1)) // R8
      else $error("coverage jumped by more than one");

endmodule

// File: rtl/gfs_top.sv
module gfs_top #(
   parameter int N     = 4,
   parameter bit IS_OR = 1'b0,
   parameter int IDXW  = (N > 1) ? $clog2(N) : 1,
   parameter int CVW   = $clog2(N + 3)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [IDXW+1:0]   fault_sel_i,
   output logic [N-1:0]      pattern_o,
   output logic              pat_valid_o,
   output logic              good_o,
   output logic              faulty_o,
   output logic              detect_o,
   output logic              done_o,
   output logic [N+1:0]      credited_o,
   output logic [CVW-1:0]    coverage_o
);
   import gfs_pkg::*;

   localparam int   NP = N + 2;
   localparam int   CW = $clog2(NP + 1);
   localparam logic CV = ctl_val(IS_OR);

   generate
      if (N < 2 || N > 8) begin : g_bad_n
         $error("gfs_top: N must lie in 2..8");
      end
   endgenerate

   seq_state_e    state_q;
   logic [CW-1:0] idx_q;
   logic          valid;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= SEQ_IDLE;
         idx_q   <= '0;
      end else if (start_i) begin
         state_q <= SEQ_RUN;
         idx_q   <= '0;
      end else if (state_q == SEQ_RUN) begin
         if (idx_q == CW'(NP - 1)) begin
            state_q <= SEQ_DONE;
            idx_q   <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign valid       = (state_q == SEQ_RUN);
   assign pat_valid_o = valid;
   assign done_o      = (state_q == SEQ_DONE);

   gfs_pattern_gen #(.N(N), .IS_OR(IS_OR), .CW(CW)) pgen_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (valid),
      .idx_i   (idx_q),
      .pat_o   (pattern_o)
   );

   // selected fault decode
   logic            sel_site;
   logic            sel_val;
   logic [IDXW-1:0] sel_idx;
   logic [N-1:0]    sel_rm;
   logic [N-1:0]    sel_frc;

   assign sel_site = fault_sel_i[IDXW+1];
   assign sel_val  = fault_sel_i[IDXW];
   assign sel_idx  = fault_sel_i[IDXW-1:0];

   generate
      for (genvar i = 0; i < N; i++) begin : g_sel
         assign sel_rm[i]  = ~sel_site & (sel_idx == IDXW'(i)) & (sel_val != CV);
         assign sel_frc[i] = ~sel_site & (sel_idx == IDXW'(i)) & (sel_val == CV);
      end
   endgenerate

   gfs_gate_model #(.N(N), .IS_OR(IS_OR)) good_i (
      .in_i        (pattern_o),
      .remove_i    ('0),
      .force_i     ('0),
      .out_stuck_i (1'b0),
      .out_val_i   (1'b0),
      .out_o       (good_o)
   );

   gfs_gate_model #(.N(N), .IS_OR(IS_OR)) bad_i (
      .in_i        (pattern_o),
      .remove_i    (sel_rm),
      .force_i     (sel_frc),
      .out_stuck_i (sel_site),
      .out_val_i   (sel_val),
      .out_o       (faulty_o)
   );

   assign detect_o = valid & (good_o ^ faulty_o);

   gfs_fault_bank #(.N(N), .IS_OR(IS_OR), .NF(NP), .CVW(CVW)) bank_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clear_i    (start_i),
      .valid_i    (valid),
      .pat_i      (pattern_o),
      .good_i     (good_o),
      .credited_o (credited_o),
      .coverage_o (coverage_o)
   );

   AST_DONE_NOT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !pat_valid_o) // R1
      else $error("done with a pattern still applied");

   AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !start_i) |=> done_o) // R9
      else $error("done dropped without start");

   AST_DETECT_IN_PATTERN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      detect_o |-> pat_valid_o) // R7
      else $error("detect outside a pattern cycle");

   AST_OUT_FAULT_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_site |-> (faulty_o == sel_val)) // R6
      else $error("output fault not applied");

   AST_FULL_COVERAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(done_o) && !$past(start_i)) |-> (coverage_o == CVW'(NP))) // R8
      else $error("coverage short after full set");

endmodule

// File: tb/gfs_top_tb_top.sv
`timescale 1ns/1ps
module gfs_top_tb_top;

   localparam int N     = 5;
   localparam int IDXW  = 3;
   localparam int CVW   = $clog2(N + 3);
   localparam int NP    = N + 2;
   localparam int NO    = 3;
   localparam int IDXWO = 2;
   localparam int CVWO  = $clog2(NO + 3);

   // per pattern for the AND gate (N=5): pattern, good output, coverage seen
   typedef struct packed {
      logic [N-1:0] pat;
      logic         good;
      logic [3:0]   cov;
   } vec_t;

   localparam vec_t VECS [NP] = '{
      '{5'b11110, 1'b0, 4'd0},
      '{5'b11101, 1'b0, 4'd1},
      '{5'b11011, 1'b0, 4'd2},
      '{5'b10111, 1'b0, 4'd3},
      '{5'b01111, 1'b0, 4'd4},
      '{5'b11111, 1'b1, 4'd5},
      '{5'b00000, 1'b0, 4'd6}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [IDXW+1:0] fsel = '0;
   logic [N-1:0] pat;
   logic valid, good, faulty, det, done;
   logic [N+1:0] cred;
   logic [CVW-1:0] cov;

   logic start_o = 1'b0;
   logic [IDXWO+1:0] fsel_o = 4'b0011;
   logic [NO-1:0] pat_o;
   logic valid_o, good_o, faulty_o, det_o, done_o;
   logic [NO+1:0] cred_o;
   logic [CVWO-1:0] cov_o;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   gfs_top #(.N(N), .IS_OR(1'b0)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .fault_sel_i(fsel),
      .pattern_o(pat), .pat_valid_o(valid), .good_o(good), .faulty_o(faulty),
      .detect_o(det), .done_o(done), .credited_o(cred), .coverage_o(cov));

   gfs_top #(.N(NO), .IS_OR(1'b1)) dut_or_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start_o), .fault_sel_i(fsel_o),
      .pattern_o(pat_o), .pat_valid_o(valid_o), .good_o(good_o), .faulty_o(faulty_o),
      .detect_o(det_o), .done_o(done_o), .credited_o(cred_o), .coverage_o(cov_o));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // faulted AND output from the requirement encoding (R5, R6, R11)
   function automatic logic ref_faulty(input logic [N-1:0] p, input logic [IDXW+1:0] fs);
      logic [N-1:0] e;
      int ix;
      e  = p;
      ix = int'(fs[IDXW-1:0]);
      if (fs[IDXW+1]) return fs[IDXW];
      if (ix < N) e[ix] = fs[IDXW];
      return &e;
   endfunction

   task automatic run_and(input logic [IDXW+1:0] fs, input string name);
      @(negedge clk);
      fsel  = fs;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < NP; k++) begin
         logic ef;
         ef = ref_faulty(VECS[k].pat, fs);
         chk(valid == 1'b1, {name, " R1 valid"}, valid, 1);
         chk(pat == VECS[k].pat, {name, " R2 R3 pattern"}, pat, VECS[k].pat);
         chk(good == VECS[k].good, {name, " R4 good"}, good, VECS[k].good);
         chk(faulty == ef, {name, " R5 faulty"}, faulty, ef);
         chk(det == (ef != VECS[k].good), {name, " R7 detect"}, det, ef != VECS[k].good);
         chk(cov == CVW'(VECS[k].cov), {name, " R8 coverage step"}, cov, VECS[k].cov);
         @(negedge clk);
      end
      chk(done == 1'b1 && valid == 1'b0, {name, " R1 done"}, {done, valid}, 2);
      chk(det == 1'b0, {name, " R7 no detect when idle"}, det, 0);
      chk(cov == CVW'(NP), {name, " R8 final coverage"}, cov, NP);
      chk(cred == '1, {name, " R8 credited map"}, cred, 7'h7f);
   endtask

   initial begin
      #(4 * 20000);
      if (!finished) begin
         fails++;
         tests++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk({valid, done, det} == 3'b000, "R10 flags in reset", {valid, done, det}, 0);
      chk(cov == '0 && cred == '0, "R10 tallies in reset", cov, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({valid, done} == 2'b00, "R10 idle after reset", {valid, done}, 0);

      // fault_sel: [4]=site(1 output) [3]=stuck value [2:0]=index
      run_and(5'b0_1_010, "in2 stuck1");
      run_and(5'b0_0_000, "in0 stuck0");
      run_and(5'b1_0_000, "out stuck0");
      run_and(5'b1_1_011, "out stuck1");
      run_and(5'b0_1_110, "R11 index out of range");

      // R9 done holds with no start
      repeat (5) @(negedge clk);
      chk(done == 1'b1 && cov == CVW'(NP), "R9 done holds", {done, cov}, NP + 8);

      // R9 restart in the middle of a run clears tallies
      @(negedge clk); start = 1'b1; fsel = 5'b0_1_001;
      @(negedge clk); start = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(cov == CVW'(2), "R8 partial coverage", cov, 2);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(pat == VECS[0].pat && cov == '0 && cred == '0, "R9 restart clears", cov, 0);
      chk(done == 1'b0, "R9 done low on restart", done, 0);
      repeat (NP) @(negedge clk);
      chk(done == 1'b1, "R1 done after restart", done, 1);

      // OR gate, N=3: complement patterns (R2, R3), index 3 selects no fault (R11)
      @(negedge clk); start_o = 1'b1;
      @(negedge clk); start_o = 1'b0;
      for (int k = 0; k < NO + 2; k++) begin
         logic [NO-1:0] ep;
         ep = (k < NO) ? NO'(1 << k) : ((k == NO) ? '0 : '1);
         chk(pat_o == ep, "R2 R3 OR pattern", pat_o, ep);
         chk(good_o == (|ep), "R4 OR good", good_o, |ep);
         chk(faulty_o == good_o && det_o == 1'b0, "R11 OR no fault", faulty_o, good_o);
         chk(cov_o == CVWO'(k), "R8 OR coverage step", cov_o, k);
         @(negedge clk);
      end
      chk(done_o == 1'b1 && cov_o == CVWO'(NO + 2), "R8 OR final", cov_o, NO + 2);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule